// File: doc/BRIEF.md
# Edge-Triggered GPIO Bank Interrupt Controller

This block watches a bank of 32 general-purpose input pins and turns selected signal transitions into a single interrupt request for the bank. Each pin passes through a two-stage synchronizer. A small per-pin state machine then tracks the synchronized level and reports a transition. Whether that transition counts depends on a 2-bit trigger code held in the pin's control word. The code can pick rising edges, falling edges, both edges, or nothing at all. Level-sensitive triggering is not offered.

A recorded transition sets a sticky pending bit in the status register. Software reads the status register and clears bits by writing ones to them. A mask register blocks chosen pins from reaching the interrupt line. Writing ones to the mask address sets mask bits. Writing ones to a separate mask-clear address removes them. The bank interrupt output is high whenever a pending bit exists whose mask bit is clear. All registers sit on a simple 32-bit register bus. A write takes effect on the clock edge that samples it. Read data appears on `rd_data` after the clock edge that samples a read, and holds until the next read.

The per-pin state machine has three states:
- `LV_INIT` is entered at reset and holds until the synchronizer has filled.
- `LV_LOW` and `LV_HIGH` track the synchronized level.

It has five transitions:
- *adopt-low* and *adopt-high* take `LV_INIT` to the level first seen, and report nothing.
- *rise* (`LV_LOW` to `LV_HIGH`) and *fall* (`LV_HIGH` to `LV_LOW`) report a transition when the trigger code selects it.
- *hold* keeps the current state.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0xFFFFFFFF (all pins masked), every trigger field reads 0, and `irq_o` is low.
- R2: Each pin p has a control word at byte offset 0x100 + 4*p. Only bits 4:3 (the trigger code) are stored. A read of the word returns the code in bits 4:3 and zero elsewhere.
- R3: Trigger code 1 sets the pin's status bit on a low-to-high change of the pin. A high-to-low change does not set it.
- R4: Trigger code 2 sets the pin's status bit on a high-to-low change. A low-to-high change does not set it.
- R5: Trigger code 3 sets the pin's status bit on either change.
- R6: Trigger code 0 disables detection, so no change of the pin sets its status bit.
- R7: The status register is at offset 0x80. Writing 1 to a bit clears that pending bit. Bits written 0 are unchanged.
- R8: The mask register is at offset 0xA0. Writing 1 to a bit sets that mask bit. Bits written 0 are unchanged. A read returns the mask.
- R9: Writing 1 to a bit at the mask-clear offset 0xC0 clears that mask bit. Bits written 0 are unchanged. A read of 0xC0 also returns the mask.
- R10: `irq_o` is high exactly when some status bit is set while its mask bit is clear. A masked pin still records its status bit.
- R11: If a qualifying transition and a clearing write of the same status bit land on the same clock edge, the bit stays set.
- R12: With the default two-stage synchronizer, a pin change made between two clock edges appears in the status register, and on an unmasked `irq_o`, after the third following rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin levels of the bank |
| req_valid | input | 1 | Register bus access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| irq_o | output | 1 | Bank interrupt request |

## Verification
The main function is exercised with a table of pin transitions. Every trigger code is paired with both a low-to-high and a high-to-low change. This separates each code's accepted edge from the one it must ignore, and shows that code 0 accepts neither.

Further directed patterns check several other behaviours:
- A mix of one-bits and zero-bits is written to the status, mask and mask-clear addresses. This shows that only the bits written as 1 change.
- A transition is lined up on the same edge as a clearing write, to expose which of the two wins.
- The interrupt line is sampled cycle by cycle after a single pin change. This pins down the latency and tells an early or late status update apart from a correct one.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned BUS_W    = 32;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned TRIG_W   = 2;
    localparam int unsigned TRIG_LSB = 3;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_MCLR   = 12'h0C0;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h100;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        LV_INIT = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2
    } lvl_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_MCLR,
        SEL_CTRL
    } reg_sel_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             ready
);

    logic [WIDTH-1:0]  stage_q [STAGES];
    logic [STAGES-1:0] fill_q;

    // Level chain plus a fill marker that says when the last stage holds a real sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= '0;
            end
            fill_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
            fill_q <= STAGES'({fill_q, 1'b1});
        end
    end

    assign q     = stage_q[STAGES-1];
    assign ready = fill_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_edge_fsm.sv
module gpio_irq_edge_fsm
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_ready,
    input  logic              lvl,
    input  logic [TRIG_W-1:0] trig,
    output logic              evt
);

    lvl_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LV_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: adopt-low, adopt-high, rise, fall, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_INIT: begin
                if (lvl_ready) begin
                    state_d = lvl ? LV_HIGH : LV_LOW;
                end
            end
            LV_LOW: begin
                if (lvl) begin
                    state_d = LV_HIGH;
                end
            end
            LV_HIGH: begin
                if (!lvl) begin
                    state_d = LV_LOW;
                end
            end
            default: state_d = LV_INIT;
        endcase
    end

    // Output: a transition is reported only when the trigger code accepts it
    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            LV_LOW:  evt = lvl  && (trig == TRIG_RISE || trig == TRIG_BOTH);
            LV_HIGH: evt = !lvl && (trig == TRIG_FALL || trig == TRIG_BOTH);
            default: evt = 1'b0;
        endcase
    end

    // R6: a disabled pin never reports
    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_OFF) |-> !evt);

    // R3: a reported transition always moves the level state
    p_evt_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (state_q != $past(state_q)));

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [BUS_W-1:0]         req_wdata,
    input  logic [NPINS-1:0]         edge_evt,
    output logic [NPINS-1:0]         status_o,
    output logic [NPINS-1:0]         mask_o,
    output logic [TRIG_W*NPINS-1:0]  trig_o,
    output logic [BUS_W-1:0]         rd_data_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [NPINS-1:0]  status_q, status_d;
    logic [NPINS-1:0]  mask_q, mask_d;
    logic [TRIG_W-1:0] trig_q [NPINS];
    logic [BUS_W-1:0]  rd_q, rd_d;

    logic [ADDR_W-1:0] ctrl_off;
    logic [IDX_W-1:0]  ctrl_idx;
    logic              ctrl_hit;
    reg_sel_e          sel;
    logic [NPINS-1:0]  wbits;
    logic              wr_stat, wr_mask, wr_mclr, wr_ctrl, rd_en;

    assign ctrl_off = req_addr - OFS_CTRL;
    assign ctrl_idx = ctrl_off[ADDR_W-1:2];
    assign ctrl_hit = (req_addr >= OFS_CTRL) && (ctrl_off[1:0] == 2'b00)
                      && (ctrl_idx < IDX_W'(NPINS));
    assign wbits    = req_wdata[NPINS-1:0];

    // Address decode
    always_comb begin
        if (!req_valid)                  sel = SEL_NONE;
        else if (req_addr == OFS_STATUS) sel = SEL_STATUS;
        else if (req_addr == OFS_MASK)   sel = SEL_MASK;
        else if (req_addr == OFS_MCLR)   sel = SEL_MCLR;
        else if (ctrl_hit)               sel = SEL_CTRL;
        else                             sel = SEL_NONE;
    end

    always_comb begin
        wr_stat = 1'b0;
        wr_mask = 1'b0;
        wr_mclr = 1'b0;
        wr_ctrl = 1'b0;
        unique case (sel)
            SEL_STATUS: wr_stat = req_write;
            SEL_MASK:   wr_mask = req_write;
            SEL_MCLR:   wr_mclr = req_write;
            SEL_CTRL:   wr_ctrl = req_write;
            default:    ;
        endcase
    end

    assign rd_en = req_valid && !req_write;

    // Status: the clear applies first, then new events are OR-ed in (event wins)
    always_comb begin
        status_d = (status_q & ~(wr_stat ? wbits : '0)) | edge_evt;
    end

    always_comb begin
        mask_d = mask_q;
        if (wr_mask) mask_d = mask_q | wbits;
        if (wr_mclr) mask_d = mask_q & ~wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '1;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPINS; p++) begin
                trig_q[p] <= TRIG_OFF;
            end
        end else if (wr_ctrl) begin
            for (int p = 0; p < NPINS; p++) begin
                if (ctrl_idx == IDX_W'(p)) begin
                    trig_q[p] <= req_wdata[TRIG_LSB +: TRIG_W];
                end
            end
        end
    end

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_trig_out
            assign trig_o[TRIG_W*p +: TRIG_W] = trig_q[p];
        end
    endgenerate

    // Read mux, captured into a register on a read access
    always_comb begin
        rd_d = '0;
        unique case (sel)
            SEL_STATUS:        rd_d = BUS_W'(status_q);
            SEL_MASK, SEL_MCLR: rd_d = BUS_W'(mask_q);
            SEL_CTRL: begin
                for (int p = 0; p < NPINS; p++) begin
                    if (ctrl_idx == IDX_W'(p)) begin
                        rd_d = BUS_W'(trig_q[p]) << TRIG_LSB;
                    end
                end
            end
            default: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_d;
        end
    end

    assign status_o  = status_q;
    assign mask_o    = mask_q;
    assign rd_data_o = rd_q;

    // R11: every event of the previous cycle is now pending, whatever was written
    p_event_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(edge_evt)) == $past(edge_evt)));

    // R3: a status bit only turns on because of an event
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(edge_evt)) == '0));

    // R7: written ones clear pending bits that had no coinciding event
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((status_q & $past(wbits) & ~$past(edge_evt)) == '0));

    // R8: written ones set mask bits
    p_mask_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> ((mask_q & $past(wbits)) == $past(wbits)));

    // R9: written ones at the mask-clear port clear mask bits
    p_mclr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_q & $past(wbits)) == '0));

endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq_o
);

    logic [NPINS-1:0]        pin_sync;
    logic                    sync_ready;
    logic [NPINS-1:0]        edge_evt;
    logic [NPINS-1:0]        status;
    logic [NPINS-1:0]        mask;
    logic [TRIG_W*NPINS-1:0] trig_flat;

    gpio_irq_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i),
        .q     (pin_sync),
        .ready (sync_ready)
    );

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            gpio_irq_edge_fsm u_edge (
                .clk       (clk),
                .rst_n     (rst_n),
                .lvl_ready (sync_ready),
                .lvl       (pin_sync[p]),
                .trig      (trig_flat[TRIG_W*p +: TRIG_W]),
                .evt       (edge_evt[p])
            );
        end
    endgenerate

    gpio_irq_regs #(
        .NPINS (NPINS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .edge_evt  (edge_evt),
        .status_o  (status),
        .mask_o    (mask),
        .trig_o    (trig_flat),
        .rd_data_o (rd_data)
    );

    assign irq_o = |(status & ~mask);

    // R10: with every pin masked the line stays low
    p_allmask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_o);

    // R10: with nothing pending the line stays low
    p_nopend_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq_o);

endmodule

// File: tb/gpio_edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_ctrl_test;

    localparam logic [11:0] A_STAT = 12'h080;
    localparam logic [11:0] A_MASK = 12'h0A0;
    localparam logic [11:0] A_MCLR = 12'h0C0;
    localparam logic [11:0] A_CTRL = 12'h100;

    // {trigger code[1:0], level before, level after, expected pending}
    localparam logic [4:0] VEC [8] = '{
        5'b01_0_1_1, 5'b01_1_0_0,
        5'b10_1_0_1, 5'b10_0_1_0,
        5'b11_0_1_1, 5'b11_1_0_1,
        5'b00_0_1_0, 5'b00_1_0_0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        bus_read(A_STAT, d); check("R1 status", d, 32'h0);
        bus_read(A_MASK, d); check("R1 mask", d, 32'hFFFF_FFFF);
        bus_read(A_CTRL + 12'd20, d); check("R1 ctrl pin5", d, 32'h0);

        // R2 control word field placement
        bus_write(A_CTRL + 12'd28, 32'hFFFF_FFFF);
        bus_read(A_CTRL + 12'd28, d); check("R2 ctrl pin7", d, 32'h0000_0018);
        bus_write(A_CTRL + 12'd124, 32'h0000_0010);
        bus_read(A_CTRL + 12'd124, d); check("R2 ctrl pin31", d, 32'h0000_0010);
        bus_read(A_CTRL + 12'd24, d); check("R2 ctrl pin6 untouched", d, 32'h0);
        bus_write(A_CTRL + 12'd28, 32'h0);
        bus_write(A_CTRL + 12'd124, 32'h0);

        // R3..R6 vector table
        for (int i = 0; i < 8; i++) begin
            logic [4:0] v;
            int pin;
            string tg;
            v = VEC[i];
            pin = i * 4 + 1;
            case (v[4:3])
                2'd1: tg = "R3";
                2'd2: tg = "R4";
                2'd3: tg = "R5";
                default: tg = "R6";
            endcase
            bus_write(A_CTRL + 12'(pin * 4), {27'b0, v[4:3], 3'b0});
            pins[pin] = v[2];
            settle();
            bus_write(A_STAT, 32'hFFFF_FFFF);
            bus_write(A_MCLR, 32'h1 << pin);
            pins[pin] = v[1];
            settle();
            check({tg, " irq"}, {31'b0, irq_o}, {31'b0, v[0]});
            bus_read(A_STAT, d);
            check({tg, " status"}, d, {31'b0, v[0]} << pin);
            bus_write(A_MASK, 32'h1 << pin);
            bus_write(A_STAT, 32'hFFFF_FFFF);
        end

        // R12 latency on pin 0
        bus_write(A_CTRL, 32'h0000_0008);
        bus_write(A_MCLR, 32'h1);
        @(negedge clk);
        pins[0] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R12 not before third edge", {31'b0, irq_o}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R12 on third edge", {31'b0, irq_o}, 32'h1);

        // R7 write-one-to-clear
        bus_write(A_CTRL + 12'd8, 32'h0000_0008);
        pins[2] = 1'b1;
        settle();
        bus_read(A_STAT, d); check("R7 two pending", d, 32'h0000_0005);
        bus_write(A_STAT, 32'h0000_0001);
        bus_read(A_STAT, d); check("R7 clear one", d, 32'h0000_0004);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, d); check("R7 zero write keeps", d, 32'h0000_0004);

        // R10 masking of a pending bit
        check("R10 masked pending low", {31'b0, irq_o}, 32'h0);
        bus_write(A_MCLR, 32'h0000_0004);
        check("R10 unmasked pending high", {31'b0, irq_o}, 32'h1);
        bus_write(A_MASK, 32'h0000_0005);
        check("R10 remasked low", {31'b0, irq_o}, 32'h0);
        bus_read(A_STAT, d); check("R10 status kept while masked", d, 32'h0000_0004);

        // R8 / R9 mask set and clear ports
        bus_write(A_MASK, 32'h0);
        bus_read(A_MASK, d); check("R8 zero write keeps", d, 32'hFFFF_FFFF);
        bus_write(A_MCLR, 32'h0000_000F);
        bus_read(A_MCLR, d); check("R9 clear low nibble", d, 32'hFFFF_FFF0);
        bus_write(A_MASK, 32'h0000_0003);
        bus_read(A_MASK, d); check("R8 set two bits", d, 32'hFFFF_FFF3);
        bus_write(A_MASK, 32'hFFFF_FFFF);

        // R11 event and clear on the same edge
        bus_write(A_CTRL + 12'd36, 32'h0000_0008);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        @(negedge clk);
        pins[9] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = A_STAT; req_wdata = 32'h0000_0200;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        bus_read(A_STAT, d); check("R11 event wins", d & 32'h0000_0200, 32'h0000_0200);
        bus_write(A_STAT, 32'h0000_0200);
        bus_read(A_STAT, d); check("R11 later clear", d & 32'h0000_0200, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule